// File: doc/BRIEF.md
# Floating-Point Register Writeback Merger

This block sits between a floating-point datapath and a 128-bit-wide floating-point register file. On the write side it takes four inputs: the operation's nominal format (single, double or quad), an already-decoded per-register element-width override, a vector flag, and the packed result bits. It combines these with the register's previous contents and produces the 128-bit word to be written and a byte-enable mask. With the mask, the register file can apply the write directly and needs no separate read-modify-write step.

There are two write behaviours. When the element width is the default and the register is scalar, the block follows plain scalar rules: the result fills the low active bits and every bit above them is forced to one, so a narrow value sits boxed inside a wide register. In every other case the bits above the active width are left untouched, and packed multi-element results fill only the low region.

On the read side the block checks a scalar source operand of a narrower format for correct boxing. A badly boxed operand is replaced by the canonical quiet NaN of its format before it reaches the datapath. Both paths pass through one output register stage. The parameter `REGISTERED` selects between one cycle of latency and a purely combinational path.

Top module: `fp_wb_merge`

## Requirements
- R1: With op_fmt 00 (single), elw_sel 00 (default) and is_vec 0, wb_data[31:0] equals res_bits[31:0], wb_data[127:32] is all ones, and wb_byte_en is 16'hFFFF.
- R2: With op_fmt 01 (double), elw_sel 00 and is_vec 0, wb_data[63:0] equals res_bits[63:0], wb_data[127:64] is all ones, and wb_byte_en is 16'hFFFF.
- R3: When elw_sel is not 00 or is_vec is 1, every bit above the active width (32 for single, 64 for double) equals prev_bits. wb_byte_en is then 16'h000F for single and 16'h00FF for double, and every byte whose enable is 0 holds the previous contents.
- R4: A packed double with elw_sel 11 (32-bit elements) places element 0 (res_bits[31:0]) in wb_data[31:0] and element 1 (res_bits[63:32]) in wb_data[63:32].
- R5: wb_elems is 1 when elw_sel is 00. Otherwise it is the active width (32, 64 or 128) divided by the element width, where elw_sel 01, 10 and 11 mean 8, 16 and 32 bits.
- R6: op_fmt 10 (quad) and the reserved code 11 both write all 128 bits from res_bits with wb_byte_en 16'hFFFF, whatever the element width or vector flag.
- R7: For a scalar source (src_elw 00, src_vec 0), a single is validly boxed only when src_bits[127:32] is all ones, and a double only when src_bits[127:64] is all ones. A valid source passes unchanged with src_boxed 1. An invalid one gives src_boxed 0 and src_data of all ones above the canonical NaN: 32'h7FC00000 for single, 64'h7FF8000000000000 for double.
- R8: A source with src_elw not 00, src_vec 1, or src_fmt quad passes through unchanged with src_boxed 1.
- R9: With REGISTERED=1, all outputs are zero in the cycle after a synchronous active-high reset. Each output reflects the inputs sampled at the previous rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output register stage |
| rst | input | 1 | Synchronous active-high reset |
| op_fmt | input | 2 | Nominal format of the result: 00 single, 01 double, 10/11 quad |
| elw_sel | input | 2 | Destination element width: 00 default, 01 8-bit, 10 16-bit, 11 32-bit |
| is_vec | input | 1 | Destination register is a vector |
| res_bits | input | 128 | Packed result bits, low-aligned |
| prev_bits | input | 128 | Previous contents of the destination register |
| src_bits | input | 128 | Raw source operand read from the register file |
| src_fmt | input | 2 | Format the source is read as, same coding as op_fmt |
| src_elw | input | 2 | Source element width, same coding as elw_sel |
| src_vec | input | 1 | Source register is a vector |
| wb_data | output | 128 | Merged word to write back |
| wb_byte_en | output | 16 | Per-byte write enable, bit i covers bits 8i+7:8i |
| wb_elems | output | 5 | Number of packed elements in the result |
| src_data | output | 128 | Source operand after the boxing check |
| src_boxed | output | 1 | Source passed the boxing check |

## Verification
The bound checker holds several properties on every cycle against the inputs from the previous edge. The low 32 result bits always pass through. Scalar single results are boxed with ones and a full enable. Overridden or vector single results keep the previous upper bits, and no byte with a cleared enable differs from the previous register. Quad writes are complete, the element count is a power of two, and a failed box check yields a canonical NaN while exempt sources pass through. What only the bench's directed scenarios can show is the exact value of each case: the position of the second packed element, the element counts for each width code, the one-bit boxing defects that must be caught, reset values and the single cycle of latency.

// File: rtl/fpwb_pkg.sv
package fpwb_pkg;

  typedef enum logic [1:0] {
    FMT_S   = 2'b00,
    FMT_D   = 2'b01,
    FMT_Q   = 2'b10,
    FMT_RSV = 2'b11
  } fmt_e;

  typedef enum logic [1:0] {
    EW_DEF = 2'b00,
    EW_8   = 2'b01,
    EW_16  = 2'b10,
    EW_32  = 2'b11
  } ew_e;

  localparam logic [31:0] CNAN_S = 32'h7FC0_0000;
  localparam logic [63:0] CNAN_D = 64'h7FF8_0000_0000_0000;

  // Active width in bits implied by a nominal format.
  function automatic logic [8:0] fmt_width(fmt_e f);
    case (f)
      FMT_S:   fmt_width = 9'd32;
      FMT_D:   fmt_width = 9'd64;
      default: fmt_width = 9'd128;
    endcase
  endfunction

endpackage

// File: rtl/fpwb_region.sv
module fpwb_region
  import fpwb_pkg::*;
#(
  parameter int unsigned FLEN   = 128,
  parameter int unsigned NBYTES = FLEN / 8,
  parameter int unsigned CNT_W  = $clog2(NBYTES) + 1
) (
  input  fmt_e              fmt,
  input  ew_e               ew,
  input  logic              is_vec,
  output logic              box_upper,
  output logic [NBYTES-1:0] byte_en,
  output logic [FLEN-1:0]   act_mask,
  output logic [CNT_W-1:0]  elems
);

  logic [8:0]        w_bits;
  logic [NBYTES-1:0] act_b;

  assign w_bits    = fmt_width(fmt);
  // Boxing applies only to a default-width scalar register.
  assign box_upper = (ew == EW_DEF) && !is_vec;

  for (genvar b = 0; b < NBYTES; b++) begin : g_byte
    assign act_b[b] = ((32'(b) * 32'd8) < {23'd0, w_bits});
    assign act_mask[b*8 +: 8] = {8{act_b[b]}};
  end

  assign byte_en = box_upper ? {NBYTES{1'b1}} : act_b;

  always_comb begin
    case (ew)
      EW_8:    elems = CNT_W'(w_bits >> 3);
      EW_16:   elems = CNT_W'(w_bits >> 4);
      EW_32:   elems = CNT_W'(w_bits >> 5);
      default: elems = CNT_W'(1);
    endcase
  end

endmodule

// File: rtl/fpwb_merge.sv
module fpwb_merge #(
  parameter int unsigned FLEN = 128
) (
  input  logic [FLEN-1:0] res,
  input  logic [FLEN-1:0] prev,
  input  logic [FLEN-1:0] act_mask,
  input  logic            box_upper,
  output logic [FLEN-1:0] merged
);

  logic [FLEN-1:0] upper_src;

  assign upper_src = box_upper ? {FLEN{1'b1}} : prev;
  assign merged    = (res & act_mask) | (upper_src & ~act_mask);

endmodule

// File: rtl/fpwb_boxchk.sv
module fpwb_boxchk
  import fpwb_pkg::*;
#(
  parameter int unsigned FLEN = 128
) (
  input  logic [FLEN-1:0] src,
  input  fmt_e            fmt,
  input  ew_e             ew,
  input  logic            is_vec,
  output logic [FLEN-1:0] out,
  output logic            ok
);

  logic scalar;
  assign scalar = (ew == EW_DEF) && !is_vec;

  always_comb begin
    ok  = 1'b1;
    out = src;
    if (scalar && fmt == FMT_S) begin
      ok = &src[FLEN-1:32];
      if (!ok) out = {{(FLEN-32){1'b1}}, CNAN_S};
    end else if (scalar && fmt == FMT_D) begin
      ok = &src[FLEN-1:64];
      if (!ok) out = {{(FLEN-64){1'b1}}, CNAN_D};
    end
  end

endmodule

// File: rtl/fp_wb_merge.sv
module fp_wb_merge
  import fpwb_pkg::*;
#(
  parameter int unsigned FLEN       = 128,
  parameter bit          REGISTERED = 1'b1,
  localparam int unsigned NBYTES    = FLEN / 8,
  localparam int unsigned CNT_W     = $clog2(NBYTES) + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        op_fmt,
  input  logic [1:0]        elw_sel,
  input  logic              is_vec,
  input  logic [FLEN-1:0]   res_bits,
  input  logic [FLEN-1:0]   prev_bits,
  input  logic [FLEN-1:0]   src_bits,
  input  logic [1:0]        src_fmt,
  input  logic [1:0]        src_elw,
  input  logic              src_vec,
  output logic [FLEN-1:0]   wb_data,
  output logic [NBYTES-1:0] wb_byte_en,
  output logic [CNT_W-1:0]  wb_elems,
  output logic [FLEN-1:0]   src_data,
  output logic              src_boxed
);

  logic              box_upper;
  logic [FLEN-1:0]   act_mask;
  logic [NBYTES-1:0] n_byte_en;
  logic [CNT_W-1:0]  n_elems;
  logic [FLEN-1:0]   n_data;
  logic [FLEN-1:0]   n_src;
  logic              n_ok;

  fpwb_region #(.FLEN(FLEN), .NBYTES(NBYTES), .CNT_W(CNT_W)) u_region (
    .fmt      (fmt_e'(op_fmt)),
    .ew       (ew_e'(elw_sel)),
    .is_vec   (is_vec),
    .box_upper(box_upper),
    .byte_en  (n_byte_en),
    .act_mask (act_mask),
    .elems    (n_elems)
  );

  fpwb_merge #(.FLEN(FLEN)) u_merge (
    .res      (res_bits),
    .prev     (prev_bits),
    .act_mask (act_mask),
    .box_upper(box_upper),
    .merged   (n_data)
  );

  fpwb_boxchk #(.FLEN(FLEN)) u_boxchk (
    .src   (src_bits),
    .fmt   (fmt_e'(src_fmt)),
    .ew    (ew_e'(src_elw)),
    .is_vec(src_vec),
    .out   (n_src),
    .ok    (n_ok)
  );

  if (REGISTERED) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst) begin
        wb_data    <= '0;
        wb_byte_en <= '0;
        wb_elems   <= '0;
        src_data   <= '0;
        src_boxed  <= 1'b0;
      end else begin
        wb_data    <= n_data;
        wb_byte_en <= n_byte_en;
        wb_elems   <= n_elems;
        src_data   <= n_src;
        src_boxed  <= n_ok;
      end
    end
  end else begin : g_comb
    assign wb_data    = n_data;
    assign wb_byte_en = n_byte_en;
    assign wb_elems   = n_elems;
    assign src_data   = n_src;
    assign src_boxed  = n_ok;
  end

endmodule

// File: rtl/fp_wb_merge_chk.sv
module fp_wb_merge_chk
  import fpwb_pkg::*;
#(
  parameter int unsigned FLEN       = 128,
  parameter bit          REGISTERED = 1'b1,
  localparam int unsigned NBYTES    = FLEN / 8,
  localparam int unsigned CNT_W     = $clog2(NBYTES) + 1
) (
  input logic              clk,
  input logic              rst,
  input logic [1:0]        op_fmt,
  input logic [1:0]        elw_sel,
  input logic              is_vec,
  input logic [FLEN-1:0]   res_bits,
  input logic [FLEN-1:0]   prev_bits,
  input logic [FLEN-1:0]   src_bits,
  input logic [1:0]        src_fmt,
  input logic [1:0]        src_elw,
  input logic              src_vec,
  input logic [FLEN-1:0]   wb_data,
  input logic [NBYTES-1:0] wb_byte_en,
  input logic [CNT_W-1:0]  wb_elems,
  input logic [FLEN-1:0]   src_data,
  input logic              src_boxed
);

  logic [1:0]      d_fmt, d_ew, d_sfmt, d_sew;
  logic            d_vec, d_svec, armed;
  logic [FLEN-1:0] d_res, d_prev, d_src;

  // Inputs aligned with the outputs they produce.
  if (REGISTERED) begin : g_dly
    always_ff @(posedge clk) begin
      d_fmt  <= op_fmt;   d_ew  <= elw_sel; d_vec  <= is_vec;
      d_res  <= res_bits; d_prev <= prev_bits;
      d_src  <= src_bits; d_sfmt <= src_fmt; d_sew <= src_elw;
      d_svec <= src_vec;
      armed  <= !rst;
    end
  end else begin : g_nodly
    assign d_fmt = op_fmt;   assign d_ew = elw_sel;  assign d_vec = is_vec;
    assign d_res = res_bits; assign d_prev = prev_bits;
    assign d_src = src_bits; assign d_sfmt = src_fmt; assign d_sew = src_elw;
    assign d_svec = src_vec;
    assign armed = 1'b1;
  end

  a_r1_single_boxed: assert property (@(posedge clk) disable iff (rst)
    armed && d_fmt == 2'b00 && d_ew == 2'b00 && !d_vec |->
      wb_data[FLEN-1:32] == {(FLEN-32){1'b1}} && wb_byte_en == {NBYTES{1'b1}});

  a_r3_upper_kept: assert property (@(posedge clk) disable iff (rst)
    armed && d_fmt == 2'b00 && (d_ew != 2'b00 || d_vec) |->
      wb_data[FLEN-1:32] == d_prev[FLEN-1:32] &&
      wb_byte_en == {{(NBYTES-4){1'b0}}, 4'hF});

  for (genvar b = 0; b < NBYTES; b++) begin : g_bytechk
    a_r3_masked_byte_kept: assert property (@(posedge clk) disable iff (rst)
      armed && !wb_byte_en[b] |-> wb_data[b*8 +: 8] == d_prev[b*8 +: 8]);
  end

  a_r4_low_passthru: assert property (@(posedge clk) disable iff (rst)
    armed |-> wb_data[31:0] == d_res[31:0]);

  a_r5_elems_pow2: assert property (@(posedge clk) disable iff (rst)
    armed |-> $countones(wb_elems) == 1);

  a_r6_quad_full: assert property (@(posedge clk) disable iff (rst)
    armed && d_fmt[1] |-> wb_data == d_res && wb_byte_en == {NBYTES{1'b1}});

  a_r7_bad_box_nan: assert property (@(posedge clk) disable iff (rst)
    armed && !src_boxed |->
      src_data == {{(FLEN-32){1'b1}}, CNAN_S} || src_data == {{(FLEN-64){1'b1}}, CNAN_D});

  a_r8_exempt_pass: assert property (@(posedge clk) disable iff (rst)
    armed && (d_sew != 2'b00 || d_svec || d_sfmt[1]) |-> src_boxed && src_data == d_src);

endmodule

bind fp_wb_merge fp_wb_merge_chk #(.FLEN(FLEN), .REGISTERED(REGISTERED)) u_chk (
  .clk(clk), .rst(rst), .op_fmt(op_fmt), .elw_sel(elw_sel), .is_vec(is_vec),
  .res_bits(res_bits), .prev_bits(prev_bits), .src_bits(src_bits),
  .src_fmt(src_fmt), .src_elw(src_elw), .src_vec(src_vec),
  .wb_data(wb_data), .wb_byte_en(wb_byte_en), .wb_elems(wb_elems),
  .src_data(src_data), .src_boxed(src_boxed)
);

// File: tb/fp_wb_merge_test.sv
module fp_wb_merge_test;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [1:0]   op_fmt = 2'b00, elw_sel = 2'b00, src_fmt = 2'b00, src_elw = 2'b00;
  logic         is_vec = 1'b0, src_vec = 1'b0;
  logic [127:0] res_bits = '0, prev_bits = '0, src_bits = '0;
  logic [127:0] wb_data, src_data;
  logic [15:0]  wb_byte_en;
  logic [4:0]   wb_elems;
  logic         src_boxed;

  int n_chk = 0;
  int n_bad = 0;

  localparam logic [127:0] RV = 128'h0123_4567_89AB_CDEF_FEDC_BA98_7654_3210;
  localparam logic [127:0] PV = 128'hA5A5_5A5A_C3C3_3C3C_9696_6969_0F0F_F0F0;
  localparam logic [127:0] ONES = {128{1'b1}};

  always #5 clk = ~clk;

  fp_wb_merge uut (
    .clk(clk), .rst(rst), .op_fmt(op_fmt), .elw_sel(elw_sel), .is_vec(is_vec),
    .res_bits(res_bits), .prev_bits(prev_bits), .src_bits(src_bits),
    .src_fmt(src_fmt), .src_elw(src_elw), .src_vec(src_vec),
    .wb_data(wb_data), .wb_byte_en(wb_byte_en), .wb_elems(wb_elems),
    .src_data(src_data), .src_boxed(src_boxed)
  );

  task automatic chk(string req, logic [127:0] act, logic [127:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Drive at a falling edge, then sample at the next falling edge (one register).
  task automatic wr(logic [1:0] f, logic [1:0] e, logic v);
    @(negedge clk);
    op_fmt = f; elw_sel = e; is_vec = v; res_bits = RV; prev_bits = PV;
    @(negedge clk);
  endtask

  task automatic rd(logic [127:0] s, logic [1:0] f, logic [1:0] e, logic v);
    @(negedge clk);
    src_bits = s; src_fmt = f; src_elw = e; src_vec = v;
    @(negedge clk);
  endtask

  task automatic t_reset;
    op_fmt = 2'b10; res_bits = RV; src_bits = RV;
    repeat (3) @(negedge clk);
    chk("R9 reset data", wb_data, '0);
    chk("R9 reset en", {112'd0, wb_byte_en}, '0);
    chk("R9 reset elems", {123'd0, wb_elems}, '0);
    chk("R9 reset src", {src_data[126:0], src_boxed}, '0);
    rst = 1'b0;
  endtask

  task automatic t_scalar;
    wr(2'b00, 2'b00, 1'b0);
    chk("R1 single boxed", wb_data, {ONES[127:32], RV[31:0]});
    chk("R1 single en", {112'd0, wb_byte_en}, 128'hFFFF);
    chk("R5 default count", {123'd0, wb_elems}, 128'd1);
    wr(2'b01, 2'b00, 1'b0);
    chk("R2 double boxed", wb_data, {ONES[127:64], RV[63:0]});
    chk("R2 double en", {112'd0, wb_byte_en}, 128'hFFFF);
  endtask

  task automatic t_preserve;
    wr(2'b00, 2'b11, 1'b0);
    chk("R3 override single data", wb_data, {PV[127:32], RV[31:0]});
    chk("R3 override single en", {112'd0, wb_byte_en}, 128'h000F);
    wr(2'b01, 2'b00, 1'b1);
    chk("R3 vec double data", wb_data, {PV[127:64], RV[63:0]});
    chk("R3 vec double en", {112'd0, wb_byte_en}, 128'h00FF);
    chk("R5 vec default count", {123'd0, wb_elems}, 128'd1);
  endtask

  task automatic t_packed;
    wr(2'b01, 2'b11, 1'b0);
    chk("R4 elem0", {96'd0, wb_data[31:0]}, {96'd0, RV[31:0]});
    chk("R4 elem1", {96'd0, wb_data[63:32]}, {96'd0, RV[63:32]});
    chk("R4 upper kept", {64'd0, wb_data[127:64]}, {64'd0, PV[127:64]});
    chk("R5 d/32 count", {123'd0, wb_elems}, 128'd2);
    wr(2'b01, 2'b01, 1'b1);
    chk("R5 d/8 count", {123'd0, wb_elems}, 128'd8);
    wr(2'b00, 2'b10, 1'b0);
    chk("R5 s/16 count", {123'd0, wb_elems}, 128'd2);
    wr(2'b10, 2'b01, 1'b0);
    chk("R5 q/8 count", {123'd0, wb_elems}, 128'd16);
  endtask

  task automatic t_quad;
    wr(2'b10, 2'b00, 1'b0);
    chk("R6 quad data", wb_data, RV);
    chk("R6 quad en", {112'd0, wb_byte_en}, 128'hFFFF);
    wr(2'b11, 2'b10, 1'b1);
    chk("R6 reserved data", wb_data, RV);
    chk("R6 reserved en", {112'd0, wb_byte_en}, 128'hFFFF);
    chk("R5 q/16 count", {123'd0, wb_elems}, 128'd8);
  endtask

  task automatic t_src;
    logic [127:0] gs, bs, gd, bd;
    gs = {ONES[127:32], 32'h3F80_0000};
    bs = gs; bs[100] = 1'b0;
    gd = {ONES[127:64], 64'h4000_0000_0000_0000};
    bd = gd; bd[64] = 1'b0;
    rd(gs, 2'b00, 2'b00, 1'b0);
    chk("R7 good single", {src_data[126:0], src_boxed}, {gs[126:0], 1'b1});
    rd(bs, 2'b00, 2'b00, 1'b0);
    chk("R7 bad single", src_data, {ONES[127:32], 32'h7FC0_0000});
    chk("R7 bad single flag", {127'd0, src_boxed}, 128'd0);
    rd(gd, 2'b01, 2'b00, 1'b0);
    chk("R7 good double", {src_data[126:0], src_boxed}, {gd[126:0], 1'b1});
    rd(bd, 2'b01, 2'b00, 1'b0);
    chk("R7 bad double", src_data, {ONES[127:64], 64'h7FF8_0000_0000_0000});
    chk("R7 bad double flag", {127'd0, src_boxed}, 128'd0);
    rd(bs, 2'b00, 2'b00, 1'b1);
    chk("R8 vec pass", {src_data[126:0], src_boxed}, {bs[126:0], 1'b1});
    rd(bd, 2'b01, 2'b01, 1'b0);
    chk("R8 elw pass", {src_data[126:0], src_boxed}, {bd[126:0], 1'b1});
    rd(PV, 2'b10, 2'b00, 1'b0);
    chk("R8 quad pass", {src_data[126:0], src_boxed}, {PV[126:0], 1'b1});
  endtask

  task automatic t_latency;
    wr(2'b10, 2'b00, 1'b0);
    @(negedge clk);
    op_fmt = 2'b00; elw_sel = 2'b11; res_bits = ~RV;
    #1;
    chk("R9 holds before edge", wb_data, RV);
    @(negedge clk);
    chk("R9 updates after edge", wb_data, {PV[127:32], ~RV[31:0]});
  endtask

  initial begin
    #(200000 * 10);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    t_reset();
    t_scalar();
    t_preserve();
    t_packed();
    t_quad();
    t_src();
    t_latency();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule